// File: doc/BRIEF.md
# Address-Matched Serial Packet Deframer

The block watches a demodulated serial bit stream for a 16-bit address word. The word may be the device's own address, formed from two 8-bit configuration bytes, or a broadcast address that software can reprogram. When the last bit of either address arrives, that bit position fixes the byte boundary for everything that follows. Three enable bits, each meaningful only when the one before it is set (address, then length, then check byte), select what happens next.

With only the address enable set, every aligned byte is handed straight to a valid/ready output. With length mode also set, the first aligned byte is a payload count. The payload bytes are stored in an internal buffer and an interrupt is raised once the packet is complete. With the check enable also set, a CRC-8 byte trails the payload, and the interrupt is raised only if that byte matches. The host drains the stored packet through a second valid/ready port. The interrupt stays high until the last stored byte is taken or the host pulses a clear.

Back-pressure: the serial input cannot be stalled. A pass-through byte is held on `out_data` until `out_ready` accepts it, but a newer byte replaces one that has not been accepted. The read port advances one byte per cycle in which `rd_valid` and `rd_ready` are both high.

Top module: `pkt_deframer`

## Requirements
- R1: After reset, `out_valid`, `rd_valid` and `irq` are low, and the broadcast address holds its default value 0xA5C3.
- R2: While `cfg_use_id` is low, no byte is produced on either port and `irq` stays low, whatever the other enables and the input bits are.
- R3: A valid address needs all 16 bits equal to {`cfg_id_hi`,`cfg_id_lo`} (high byte received first) or to the broadcast address. A word that differs in any single bit is not a match.
- R4: A pulse on `gid_we` loads `gid_wdata` as the broadcast address. After that, the new value matches and the old default does not.
- R5: No byte leaves before a match. Once a match occurs, the next 8 accepted bits form the first byte, MSB first, and every following group of 8 bits forms the next byte, whatever the number of bits that came before the address.
- R6: With `cfg_use_id`=1 and `cfg_len_mode`=0, each aligned byte appears on `out_data` with `out_valid` high in the cycle after its last bit. The byte is held until `out_ready` is high, and a newer byte overwrites one that has not been accepted.
- R7: With `cfg_use_id`=1 and `cfg_len_mode`=1, the first byte after the address is a count N from 1 to 64 that excludes the check byte. The next N bytes are stored, and `irq` rises in the cycle after the last of them when `cfg_crc_chk`=0.
- R8: A count of 0 or greater than 64 abandons the packet. `irq` stays low and the block hunts for the address again.
- R9: With all three enables set, the byte after the payload is compared to a CRC-8 computed with polynomial 0x07 and initial value 0x00, MSB first, over the count byte and the payload. `irq` rises only on equality. A mismatch drops the packet and the block hunts again.
- R10: While `irq` is high, `rd_valid` is high and `rd_data` gives the stored bytes in arrival order, one per accepted `rd_ready`, with `rd_last` high on byte N. Accepting byte N lowers `irq` and `rd_valid` and restarts the hunt.
- R11: A pulse on `irq_clr` while `irq` is high lowers `irq` and `rd_valid` in the next cycle and drops the packet.
- R12: `cfg_crc_chk` has no effect without `cfg_len_mode`: the block still streams bytes directly.
- R13: Input bits that arrive while a stored packet is pending are ignored. `irq` and the byte offered on `rd_data` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_id_hi | input | 8 | Device address, high byte |
| cfg_id_lo | input | 8 | Device address, low byte |
| cfg_use_id | input | 1 | Address hunting enable |
| cfg_len_mode | input | 1 | Length-prefixed buffering enable |
| cfg_crc_chk | input | 1 | Trailing check byte enable |
| gid_we | input | 1 | Broadcast address write strobe |
| gid_wdata | input | 16 | Broadcast address write value |
| bit_vld | input | 1 | Serial bit strobe |
| bit_in | input | 1 | Serial data bit |
| out_valid | output | 1 | Pass-through byte valid |
| out_ready | input | 1 | Pass-through byte accept |
| out_data | output | 8 | Pass-through byte |
| rd_valid | output | 1 | Stored byte valid |
| rd_ready | input | 1 | Stored byte accept |
| rd_data | output | 8 | Stored byte |
| rd_last | output | 1 | Final stored byte marker |
| irq | output | 1 | Packet ready interrupt |
| irq_clr | input | 1 | Interrupt clear and packet discard |

## Verification
Address detection is driven with both legal addresses and with all sixteen single-bit corruptions of the device address. This separates a full 16-bit compare from a partial one. Pass-through is run with 0 to 7 filler bits ahead of the address, which shows whether alignment follows the match point or a free-running bit count. Buffered mode sweeps every count from 1 to 64, with and without a good check byte, plus a corrupted check byte at regular counts and the counts 0, 65 and 255. This exposes off-by-one errors in the payload end, the CRC arithmetic and the length bounds.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

  typedef enum logic [2:0] {
    S_HUNT,
    S_STREAM,
    S_LEN,
    S_PAYLOAD,
    S_CRC,
    S_DONE
  } dfr_state_e;

  // One byte through CRC-8 (poly 0x07), MSB first
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc, input logic [7:0] din);
    logic [7:0] c;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ din[i]) c = {c[6:0], 1'b0} ^ 8'h07;
      else               c = {c[6:0], 1'b0};
    end
    return c;
  endfunction

endpackage

// File: rtl/deframer_id_hunt.sv
module deframer_id_hunt #(
  parameter int          ID_W    = 16,
  parameter logic [15:0] GID_RST = 16'hA5C3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hunt,
  input  logic            bit_vld,
  input  logic            bit_in,
  input  logic [ID_W-1:0] dev_id,
  input  logic            gid_we,
  input  logic [ID_W-1:0] gid_wdata,
  output logic            match
);
  localparam int FILL_W = $clog2(ID_W + 1);

  logic [ID_W-1:0]   win, gid;
  logic [FILL_W-1:0] fill;
  logic [ID_W-1:0]   win_nxt;

  assign win_nxt = {win[ID_W-2:0], bit_in};
  assign match   = hunt && bit_vld && (fill >= FILL_W'(ID_W - 1)) &&
                   ((win_nxt == dev_id) || (win_nxt == gid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gid <= GID_RST[ID_W-1:0];
    else if (gid_we) gid <= gid_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win  <= '0;
      fill <= '0;
    end else if (!hunt) begin
      win  <= '0;
      fill <= '0;
    end else if (bit_vld) begin
      win <= win_nxt;
      if (fill != FILL_W'(ID_W)) fill <= fill + 1'b1;
    end
  end

  // R3
  match_leaves_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !hunt);

endmodule

// File: rtl/deframer_buf.sv
module deframer_buf #(
  parameter int DEPTH  = 64,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_start,
  input  logic              rd_adv,
  output logic [BYTE_W-1:0] rd_data,
  output logic [$clog2(DEPTH):0] wr_idx,
  output logic [$clog2(DEPTH):0] rd_idx
);
  localparam int AW = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [AW:0]       wptr, rptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_rst)     wptr <= '0;
      else if (wr_en) wptr <= wptr + 1'b1;
      if (rd_start)    rptr <= '0;
      else if (rd_adv) rptr <= rptr + 1'b1;
    end
  end

  assign rd_data = mem[rptr[AW-1:0]];
  assign wr_idx  = wptr;
  assign rd_idx  = rptr;

  // R7
  buf_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wptr < (AW+1)'(DEPTH)));

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_adv && !rd_start) |=> $stable(rptr));

endmodule

// File: rtl/pkt_deframer.sv
module pkt_deframer
  import deframer_pkg::*;
#(
  parameter int          BYTE_W  = 8,
  parameter int          DEPTH   = 64,
  parameter logic [15:0] GID_RST = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] cfg_id_hi,
  input  logic [BYTE_W-1:0] cfg_id_lo,
  input  logic              cfg_use_id,
  input  logic              cfg_len_mode,
  input  logic              cfg_crc_chk,
  input  logic              gid_we,
  input  logic [2*BYTE_W-1:0] gid_wdata,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_last,
  output logic              irq,
  input  logic              irq_clr
);
  localparam int ID_W = 2 * BYTE_W;
  localparam int BCW  = $clog2(BYTE_W);
  localparam int CW   = $clog2(DEPTH) + 1;

  dfr_state_e        st, st_nxt;
  logic [BCW-1:0]    bcnt;
  logic [BYTE_W-1:0] bsr, byte_now, len_r, crc_r;
  logic              collect, byte_done, id_match, len_on, crc_on, len_ok;
  logic              wr_en, rd_adv;
  logic [CW-1:0]     wr_idx, rd_idx;

  assign len_on    = cfg_use_id && cfg_len_mode;
  assign crc_on    = len_on && cfg_crc_chk;
  assign collect   = st inside {S_STREAM, S_LEN, S_PAYLOAD, S_CRC};
  assign byte_now  = {bsr[BYTE_W-2:0], bit_in};
  assign byte_done = collect && bit_vld && (bcnt == BCW'(BYTE_W - 1));
  assign len_ok    = (byte_now != '0) && (byte_now <= BYTE_W'(DEPTH));

  deframer_id_hunt #(.ID_W(ID_W), .GID_RST(GID_RST)) u_hunt (
    .clk, .rst_n,
    .hunt      (st == S_HUNT && cfg_use_id),
    .bit_vld, .bit_in,
    .dev_id    ({cfg_id_hi, cfg_id_lo}),
    .gid_we, .gid_wdata,
    .match     (id_match)
  );

  assign wr_en  = (st == S_PAYLOAD) && byte_done;
  assign rd_adv = (st == S_DONE) && rd_ready;

  deframer_buf #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_buf (
    .clk, .rst_n,
    .wr_rst   (st == S_LEN),
    .wr_en,
    .wr_data  (byte_now),
    .rd_start (st != S_DONE),
    .rd_adv,
    .rd_data,
    .wr_idx,
    .rd_idx
  );

  assign rd_valid = (st == S_DONE);
  assign irq      = (st == S_DONE);
  assign rd_last  = (BYTE_W'(rd_idx) + 1'b1 == len_r);

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_HUNT:    if (id_match) st_nxt = len_on ? S_LEN : S_STREAM;
      S_STREAM:  if (!cfg_use_id || cfg_len_mode) st_nxt = S_HUNT;
      S_LEN:     if (!len_on) st_nxt = S_HUNT;
                 else if (byte_done) st_nxt = len_ok ? S_PAYLOAD : S_HUNT;
      S_PAYLOAD: if (!len_on) st_nxt = S_HUNT;
                 else if (byte_done && (BYTE_W'(wr_idx) + 1'b1 == len_r))
                   st_nxt = crc_on ? S_CRC : S_DONE;
      S_CRC:     if (byte_done) st_nxt = (byte_now == crc_r) ? S_DONE : S_HUNT;
      S_DONE:    if (irq_clr || (rd_ready && rd_last)) st_nxt = S_HUNT;
      default:   st_nxt = S_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_HUNT;
      bcnt  <= '0;
      bsr   <= '0;
      len_r <= '0;
      crc_r <= '0;
    end else begin
      st <= st_nxt;
      if (!collect || st_nxt == S_HUNT) bcnt <= '0;
      else if (bit_vld)                 bcnt <= bcnt + 1'b1;
      if (collect && bit_vld) bsr <= byte_now;
      if (st == S_LEN && byte_done) begin
        len_r <= byte_now;
        crc_r <= crc8_byte(8'h00, byte_now);
      end else if (wr_en) begin
        crc_r <= crc8_byte(crc_r, byte_now);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (st == S_STREAM && byte_done) begin
      out_valid <= 1'b1;
      out_data  <= byte_now;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5
  quiet_before_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_STREAM && !out_valid) |=> !out_valid);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !(st == S_STREAM && byte_done))
      |=> (out_valid && $stable(out_data)));

  // R9
  crc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $past(crc_on)) |-> ($past(st) == S_CRC));

  // R10
  last_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last) |=> !irq);

  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_clr) |=> (!irq && !rd_valid));

endmodule

// File: tb/pkt_deframer_tb.sv
module pkt_deframer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_id_hi = 8'h2D, cfg_id_lo = 8'hD4;
  logic cfg_use_id = 1'b0, cfg_len_mode = 1'b0, cfg_crc_chk = 1'b0;
  logic gid_we = 1'b0;
  logic [15:0] gid_wdata = '0;
  logic bit_vld = 1'b0, bit_in = 1'b0;
  logic out_valid, out_ready = 1'b1;
  logic [7:0] out_data;
  logic rd_valid, rd_ready = 1'b0, rd_last, irq, irq_clr = 1'b0;
  logic [7:0] rd_data;

  localparam logic [15:0] DEV = 16'h2DD4;
  localparam logic [15:0] GDEF = 16'hA5C3;

  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  pkt_deframer u_dut (
    .clk, .rst_n, .cfg_id_hi, .cfg_id_lo, .cfg_use_id, .cfg_len_mode,
    .cfg_crc_chk, .gid_we, .gid_wdata, .bit_vld, .bit_in, .out_valid,
    .out_ready, .out_data, .rd_valid, .rd_ready, .rd_data, .rd_last,
    .irq, .irq_clr
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); bit_in = b; bit_vld = 1'b1;
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic send_word(input logic [15:0] w);
    send_byte(w[15:8]);
    send_byte(w[7:0]);
  endtask

  task automatic rehunt();
    @(negedge clk); cfg_use_id = 1'b0;
    @(negedge clk); cfg_use_id = 1'b1;
  endtask

  function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
    logic [8:0] r;
    r = {1'b0, c};
    for (int i = 7; i >= 0; i--) begin
      r = {r[7:0], 1'b0};
      if (r[8] ^ d[i]) r[7:0] = r[7:0] ^ 8'h07;
    end
    return r[7:0];
  endfunction

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 37) + (seed * 11) + 5);
  endfunction

  task automatic read_all(input int n, input int seed, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(rd_valid === 1'b1, req, rd_valid, 1);
      chk(rd_data === pat(i, seed), req, rd_data, pat(i, seed));
      chk(rd_last === (i == n - 1), req, rd_last, (i == n - 1));
      rd_ready = 1'b1;
      @(negedge clk); rd_ready = 1'b0;
    end
    chk(irq === 1'b0 && rd_valid === 1'b0, "R10", irq, 0);
  endtask

  // Sends address, count, payload and optionally a check byte
  task automatic run_pkt(input int n, input bit use_crc, input bit bad, input int seed);
    logic [7:0] c;
    send_word(DEV);
    send_byte(8'(n));
    c = crc_ref(8'h00, 8'(n));
    for (int i = 0; i < n; i++) begin
      send_byte(pat(i, seed));
      c = crc_ref(c, pat(i, seed));
    end
    if (use_crc) begin
      chk(irq === 1'b0, "R9", irq, 0);
      send_byte(bad ? (c ^ 8'h01) : c);
    end
    if (use_crc && bad) begin
      chk(irq === 1'b0 && rd_valid === 1'b0, "R9", irq, 0);
    end else begin
      chk(irq === 1'b1, use_crc ? "R9" : "R7", irq, 1);
      read_all(n, seed, "R10");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid === 1'b0 && rd_valid === 1'b0 && irq === 1'b0, "R1", {out_valid, rd_valid, irq}, 0);

    // R2: address hunting off
    send_word(DEV); send_byte(8'h5A);
    chk(out_valid === 1'b0 && irq === 1'b0, "R2", out_valid, 0);
    cfg_len_mode = 1'b1;
    send_word(DEV); send_byte(8'h01); send_byte(8'h33);
    chk(irq === 1'b0 && rd_valid === 1'b0, "R2", irq, 0);
    cfg_len_mode = 1'b0;

    // R1/R4: default broadcast address after reset
    cfg_use_id = 1'b1;
    send_word(GDEF); send_byte(8'hC7);
    chk(out_valid === 1'b1 && out_data === 8'hC7, "R1", out_data, 8'hC7);

    // R5/R6: alignment sweep with 0..7 filler bits
    for (int k = 0; k < 8; k++) begin
      rehunt();
      for (int j = 0; j < k; j++) send_bit(1'b0);
      chk(out_valid === 1'b0, "R5", out_valid, 0);
      send_word(DEV);
      chk(out_valid === 1'b0, "R5", out_valid, 0);
      for (int b = 0; b < 3; b++) begin
        send_byte(pat(b, k));
        chk(out_valid === 1'b1 && out_data === pat(b, k), "R6", out_data, pat(b, k));
      end
    end

    // R6: hold and overwrite without acceptance
    out_ready = 1'b0;
    send_byte(8'h11); send_byte(8'h22);
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b1 && out_data === 8'h22, "R6", out_data, 8'h22);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R6", out_valid, 0);

    // R3: every single-bit corruption of the device address is rejected
    for (int b = 0; b < 16; b++) begin
      rehunt();
      send_word(DEV ^ (16'h1 << b)); send_byte(8'h00);
      chk(out_valid === 1'b0, "R3", b, 0);
    end

    // R12: check-byte enable alone still streams
    cfg_crc_chk = 1'b1;
    rehunt();
    send_word(DEV); send_byte(8'h6E);
    chk(out_valid === 1'b1 && out_data === 8'h6E && irq === 1'b0, "R12", out_data, 8'h6E);
    cfg_crc_chk = 1'b0;

    // R4: reprogrammed broadcast address
    @(negedge clk); gid_wdata = 16'h1234; gid_we = 1'b1;
    @(negedge clk); gid_we = 1'b0;
    rehunt();
    send_word(16'h1234); send_byte(8'h9B);
    chk(out_valid === 1'b1 && out_data === 8'h9B, "R4", out_data, 8'h9B);
    rehunt();
    send_word(GDEF); send_byte(8'h00);
    chk(out_valid === 1'b0, "R4", out_valid, 0);

    // R8: illegal counts
    cfg_len_mode = 1'b1;
    rehunt();
    send_word(DEV); send_byte(8'd0); send_byte(8'h44);
    chk(irq === 1'b0 && rd_valid === 1'b0, "R8", irq, 0);
    send_word(DEV); send_byte(8'd65);
    for (int i = 0; i < 65; i++) send_byte(8'h0F);
    chk(irq === 1'b0 && rd_valid === 1'b0, "R8", irq, 0);
    send_word(DEV); send_byte(8'd255); send_byte(8'h00);
    chk(irq === 1'b0, "R8", irq, 0);
    rehunt();

    // R7: every legal count, no check byte
    for (int n = 1; n <= 64; n++) run_pkt(n, 1'b0, 1'b0, n);

    // R13: input ignored while packet pending
    send_word(DEV); send_byte(8'd3);
    for (int i = 0; i < 3; i++) send_byte(pat(i, 7));
    send_word(DEV); send_byte(8'h55);
    chk(irq === 1'b1 && rd_data === pat(0, 7), "R13", rd_data, pat(0, 7));
    read_all(3, 7, "R13");

    // R11: clear discards pending packet
    send_word(DEV); send_byte(8'd2);
    send_byte(pat(0, 3)); send_byte(pat(1, 3));
    chk(irq === 1'b1, "R11", irq, 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq === 1'b0 && rd_valid === 1'b0, "R11", irq, 0);

    // R9: check byte, good at every count, bad at a spread of counts
    cfg_crc_chk = 1'b1;
    for (int n = 1; n <= 64; n++) run_pkt(n, 1'b1, 1'b0, n + 100);
    for (int n = 1; n <= 64; n += 9) run_pkt(n, 1'b1, 1'b1, n + 50);
    run_pkt(64, 1'b1, 1'b1, 9);
    run_pkt(5, 1'b1, 1'b0, 9);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule